// File: doc/BRIEF.md
# I2C Serial Clock Period Generator

This block produces the serial clock of an I2C master from programmable counts, running on the controller clock. Two pairs of counts are held on its inputs: one pair for standard mode and one for fast mode. A single select input picks the pair. While the run input is high, the block alternates a driven-low phase and a released phase on an open-drain output. While the run input is low, the line is left released and all counting is cleared.

The low phase is timed from the cycle in which the block starts pulling the line low, so the line's fall time is part of the counted low period. The released phase only starts counting once the line has been seen high through a two-stage synchronizer. A slave that holds the line low therefore lengthens the released phase. With no such hold, each phase has a fixed overhead on top of its programmed count: one cycle for the low phase and eight cycles for the released phase.

A companion byte engine uses two strobes. One marks the first cycle of each low phase, which is when data may change. The other marks the cycle in which the high count starts, which is when a bit may be sampled.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, and while `enable` is 0, `sclDriveLow`, `dataChange` and `dataSample` are all 0.
- R2: With the line following the drive, a low phase lasts exactly effL+1 cycles of `sclDriveLow`=1, where effL is the selected low count after clamping.
- R3: With the line following the drive, the released phase between two low phases lasts exactly effH+8 cycles of `sclDriveLow`=0, where effH is the selected high count after clamping.
- R4: `fastMode`=1 selects the pair `fastHighCnt`/`fastLowCnt`, and `fastMode`=0 selects the pair `stdHighCnt`/`stdLowCnt`.
- R5: Any count below 6 is used as 6. Counts of 6 or more are used unchanged.
- R6: The high count starts only after `sclIn` has been seen high through two synchronizer flops. Each extra cycle in which a slave holds `sclIn` low after release lengthens the released phase by one cycle.
- R7: Dropping `enable` in any phase releases the line in the next cycle. This includes the last cycle of a released phase, where disable wins over starting a new low phase. The next enable starts a fresh low phase of full length.
- R8: `dataChange` pulses for one cycle on the first cycle of each low phase (position 1). `dataSample` pulses for one cycle on the 4th released cycle when the line rises at once, which is where the high count starts. Neither strobe is asserted at any other time.
- R9: The pair is sampled at the start of each phase. Changing `fastMode` during a phase leaves that phase's length unchanged and takes effect at the next phase start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run (1) or stop and release (0) |
| fastMode | input | 1 | 1 selects the fast pair, 0 selects the standard pair |
| stdHighCnt | input | CNT_W | Standard-mode high count |
| stdLowCnt | input | CNT_W | Standard-mode low count |
| fastHighCnt | input | CNT_W | Fast-mode high count |
| fastLowCnt | input | CNT_W | Fast-mode low count |
| sclIn | input | 1 | Level read back from the SCL line |
| sclDriveLow | output | 1 | Open-drain control: 1 pulls SCL low, 0 releases it |
| dataChange | output | 1 | Strobe on the first cycle of a low phase |
| dataSample | output | 1 | Strobe when the high count starts |

## Verification
Two events can fall in the same cycle: the terminal count of a released phase, and a drop of `enable`. Only one of them can decide the next state. The bench provokes this by counting released cycles from the release and clearing `enable` on exactly the last one. The check passes only if the line stays released afterwards, with no new low phase and no `dataChange`. A second overlap comes from a slave hold that ends while the synchronizer is still filling. This is judged by checking that the released phase and the position of `dataSample` both shift by exactly the number of hold cycles.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LOW    = 2'd1,
    PH_WAITHI = 2'd2,
    PH_HIGH   = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic loadLow;
    logic loadHigh;
    logic dec;
  } ctrlStrobe_t;

endpackage

// File: rtl/scl_gen_dp.sv
module scl_gen_dp
  import scl_gen_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_CNT    = 6,
  parameter int HIGH_EXTRA = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic             fastMode,
  input  logic [CNT_W-1:0] stdHighCnt,
  input  logic [CNT_W-1:0] stdLowCnt,
  input  logic [CNT_W-1:0] fastHighCnt,
  input  logic [CNT_W-1:0] fastLowCnt,
  output logic             cntZero
);

  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] MIN_V   = CW'(MIN_CNT);
  localparam logic [CW-1:0] EXTRA_V = CW'(HIGH_EXTRA);

  // index 0 = standard pair, 1 = fast pair
  logic [1:0][CNT_W-1:0] rawHigh, rawLow;
  logic [1:0][CW-1:0]    effHigh, effLow;

  assign rawHigh[0] = stdHighCnt;
  assign rawHigh[1] = fastHighCnt;
  assign rawLow[0]  = stdLowCnt;
  assign rawLow[1]  = fastLowCnt;

  for (genvar m = 0; m < 2; m++) begin : g_clamp
    logic [CW-1:0] hExt, lExt;
    assign hExt = {1'b0, rawHigh[m]};
    assign lExt = {1'b0, rawLow[m]};
    assign effHigh[m] = (hExt < MIN_V) ? MIN_V : hExt;
    assign effLow[m]  = (lExt < MIN_V) ? MIN_V : lExt;
  end

  logic [CW-1:0] cntQ;
  logic [CW-1:0] lowLoad, highLoad;

  assign lowLoad  = effLow[fastMode];
  assign highLoad = effHigh[fastMode] + EXTRA_V;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cntQ <= '0;
    else if (strobe.clear)    cntQ <= '0;
    else if (strobe.loadLow)  cntQ <= lowLoad;
    else if (strobe.loadHigh) cntQ <= highLoad;
    else if (strobe.dec)      cntQ <= cntQ - CW'(1);
  end

  assign cntZero = (cntQ == '0);

endmodule

// File: rtl/scl_gen_ctrl.sv
module scl_gen_ctrl
  import scl_gen_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        sclIn,
  input  logic        cntZero,
  output ctrlStrobe_t strobe,
  output logic        sclDriveLow,
  output logic        dataChange,
  output logic        dataSample
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineHigh;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= 1'b0;
      else if (s == 0) syncQ[s] <= sclIn;
      else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  assign lineHigh = syncQ[SYNC_STAGES-1];

  phase_e phaseQ, phaseNext;

  always_comb begin
    phaseNext = phaseQ;
    strobe    = '0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (enable) begin
          phaseNext      = PH_LOW;
          strobe.loadLow = 1'b1;
        end else begin
          strobe.clear = 1'b1;
        end
      end
      PH_LOW: begin
        if (!enable) begin
          phaseNext    = PH_IDLE;
          strobe.clear = 1'b1;
        end else if (cntZero) begin
          phaseNext = PH_WAITHI;
        end else begin
          strobe.dec = 1'b1;
        end
      end
      PH_WAITHI: begin
        if (!enable) begin
          phaseNext    = PH_IDLE;
          strobe.clear = 1'b1;
        end else if (lineHigh) begin
          phaseNext       = PH_HIGH;
          strobe.loadHigh = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!enable) begin
          phaseNext    = PH_IDLE;
          strobe.clear = 1'b1;
        end else if (cntZero) begin
          phaseNext      = PH_LOW;
          strobe.loadLow = 1'b1;
        end else begin
          strobe.dec = 1'b1;
        end
      end
      default: begin
        phaseNext    = PH_IDLE;
        strobe.clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ     <= PH_IDLE;
      dataChange <= 1'b0;
      dataSample <= 1'b0;
    end else begin
      phaseQ     <= phaseNext;
      dataChange <= (phaseNext == PH_LOW)  && (phaseQ != PH_LOW);
      dataSample <= (phaseNext == PH_HIGH) && (phaseQ != PH_HIGH);
    end
  end

  assign sclDriveLow = (phaseQ == PH_LOW);

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_CNT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             fastMode,
  input  logic [CNT_W-1:0] stdHighCnt,
  input  logic [CNT_W-1:0] stdLowCnt,
  input  logic [CNT_W-1:0] fastHighCnt,
  input  logic [CNT_W-1:0] fastLowCnt,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             dataChange,
  output logic             dataSample
);

  // released phase = (SYNC_STAGES+1) wait cycles + (effH + HIGH_EXTRA + 1) counted
  localparam int HIGH_EXTRA = 8 - (SYNC_STAGES + 1) - 1;

  ctrlStrobe_t strobe;
  logic        cntZero;

  scl_gen_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .sclIn       (sclIn),
    .cntZero     (cntZero),
    .strobe      (strobe),
    .sclDriveLow (sclDriveLow),
    .dataChange  (dataChange),
    .dataSample  (dataSample)
  );

  scl_gen_dp #(
    .CNT_W      (CNT_W),
    .MIN_CNT    (MIN_CNT),
    .HIGH_EXTRA (HIGH_EXTRA)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .fastMode    (fastMode),
    .stdHighCnt  (stdHighCnt),
    .stdLowCnt   (stdLowCnt),
    .fastHighCnt (fastHighCnt),
    .fastLowCnt  (fastLowCnt),
    .cntZero     (cntZero)
  );

endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclDriveLow,
  input logic dataChange,
  input logic dataSample
);

  // R1 / R7: disabled means released one cycle later
  assert_release_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclDriveLow);

  // R5 / R2: a completed low phase lasted at least the clamped minimum + 1
  assert_min_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sclDriveLow) && $past(enable)) |-> $past(sclDriveLow, 7));

  // R8: change strobe only while driving low
  assert_change_in_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataChange |-> sclDriveLow);

  // R8: every new low phase is announced
  assert_low_start_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDriveLow) |-> dataChange);

  // R6: sample strobe only while released
  assert_sample_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataSample |-> !sclDriveLow);

  // R8: strobes are single-cycle
  assert_sample_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataSample |=> !dataSample);

endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .sclDriveLow (sclDriveLow),
  .dataChange  (dataChange),
  .dataSample  (dataSample)
);

// File: tb/scl_period_gen_tb.sv
module scl_period_gen_tb;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             fastMode = 1'b0;
  logic [CNT_W-1:0] stdHighCnt = '0, stdLowCnt = '0, fastHighCnt = '0, fastLowCnt = '0;
  logic             stretch = 1'b0;
  logic             sclIn;
  logic             sclDriveLow, dataChange, dataSample;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // open-drain line: low if the block or a slave pulls it
  assign sclIn = !sclDriveLow && !stretch;

  scl_period_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .fastMode(fastMode),
    .stdHighCnt(stdHighCnt), .stdLowCnt(stdLowCnt),
    .fastHighCnt(fastHighCnt), .fastLowCnt(fastLowCnt),
    .sclIn(sclIn), .sclDriveLow(sclDriveLow),
    .dataChange(dataChange), .dataSample(dataSample)
  );

  function automatic int effCnt(input int v);
    return (v < 6) ? 6 : v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // must be called at a negedge; measures one low and the following released phase
  task automatic measure(output int lowLen, output int highLen,
                         output int chgPos, output int smpPos, input int holdCyc);
    lowLen = 0; highLen = 0; chgPos = -1; smpPos = -1;
    while (!sclDriveLow) @(negedge clk);
    if (holdCyc > 0) stretch = 1'b1;
    while (sclDriveLow) begin
      lowLen++;
      if (dataChange && chgPos < 0) chgPos = lowLen;
      @(negedge clk);
    end
    while (!sclDriveLow) begin
      highLen++;
      if (dataSample && smpPos < 0) smpPos = highLen;
      if (highLen == holdCyc + 1) stretch = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic stopRun();
    @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 drive after reset", sclDriveLow, 0);
    check("R1 change strobe after reset", dataChange, 0);
    check("R1 sample strobe after reset", dataSample, 0);
    repeat (5) @(negedge clk);
    check("R1 drive while disabled", sclDriveLow, 0);
  endtask

  task automatic testPeriod(input string req, input bit fm, input int h, input int l);
    int lo, hi, cp, sp;
    fastMode = fm;
    if (fm) begin fastHighCnt = CNT_W'(h); fastLowCnt = CNT_W'(l); end
    else    begin stdHighCnt  = CNT_W'(h); stdLowCnt  = CNT_W'(l); end
    @(negedge clk);
    enable = 1'b1;
    measure(lo, hi, cp, sp, 0);
    check({req, " low length"}, lo, effCnt(l) + 1);
    check({req, " high length"}, hi, effCnt(h) + 8);
    check({req, " R8 change position"}, cp, 1);
    check({req, " R8 sample position"}, sp, 4);
    measure(lo, hi, cp, sp, 0);
    check({req, " second low"}, lo, effCnt(l) + 1);
    check({req, " second high"}, hi, effCnt(h) + 8);
    stopRun();
  endtask

  task automatic testStretch();
    int lo, hi, cp, sp;
    fastMode = 1'b0; stdHighCnt = 10; stdLowCnt = 12;
    @(negedge clk);
    enable = 1'b1;
    measure(lo, hi, cp, sp, 5);
    check("R6 stretched high", hi, 10 + 8 + 5);
    check("R6 sample shifted", sp, 4 + 5);
    check("R6 low unaffected", lo, 13);
    stopRun();
  endtask

  task automatic testModeSwitch();
    int lo, hi, cp, sp;
    fastMode = 1'b0; stdHighCnt = 10; stdLowCnt = 20; fastHighCnt = 7; fastLowCnt = 9;
    @(negedge clk);
    enable = 1'b1;
    measure(lo, hi, cp, sp, 0);
    fastMode = 1'b1;  // now in first cycle of the next (standard-loaded) low
    measure(lo, hi, cp, sp, 0);
    check("R9 low keeps old pair", lo, 21);
    check("R9 high uses new pair R4", hi, 15);
    stopRun();
  endtask

  task automatic testDisableMidLow();
    int lo, hi, cp, sp;
    fastMode = 1'b0; stdHighCnt = 10; stdLowCnt = 20;
    @(negedge clk);
    enable = 1'b1;
    while (!sclDriveLow) @(negedge clk);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R7 released after disable", sclDriveLow, 0);
    repeat (4) @(negedge clk);
    enable = 1'b1;
    measure(lo, hi, cp, sp, 0);
    check("R7 fresh low after re-enable", lo, 21);
    stopRun();
  endtask

  task automatic testDisableAtTerminal();
    int lo, hi, cp, sp;
    int stillLow, chg;
    fastMode = 1'b1; fastHighCnt = 7; fastLowCnt = 9;
    @(negedge clk);
    enable = 1'b1;
    while (!sclDriveLow) @(negedge clk);
    while (sclDriveLow) @(negedge clk);
    // now at released cycle 1; last released cycle is 7+8
    repeat (7 + 8 - 1) @(negedge clk);
    enable = 1'b0;
    stillLow = 0; chg = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (sclDriveLow) stillLow++;
      if (dataChange) chg++;
    end
    check("R7 disable wins at terminal count", stillLow, 0);
    check("R8 no change strobe after disable", chg, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPeriod("R2 R3 standard", 1'b0, 10, 20);
    testPeriod("R4 fast", 1'b1, 7, 9);
    testPeriod("R5 clamp low values", 1'b0, 0, 2);
    testPeriod("R5 boundary six", 1'b1, 6, 6);
    testPeriod("R5 above bound", 1'b0, 7, 7);
    testStretch();
    testModeSwitch();
    testDisableMidLow();
    testDisableAtTerminal();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule